// File: doc/BRIEF.md
# Glitch-free card clock divider

This block turns a single oscillator clock into two outputs. The first is an auxiliary clock at half the oscillator frequency. It starts as soon as reset is released and never stops, so it can clock other logic even while no card session is open. The second is the card clock. It runs at either that half rate or a quarter rate, and it is present only while the sequencer has enabled it. Two active-low select inputs choose the rate.

All logic runs on the oscillator clock, and both outputs come straight from flops. The select inputs and the enable are captured once per auxiliary period through a two-stage synchronizer. A new rate, a start or a stop is taken up only at the point where a complete low phase of the card clock ends. As a result, every pulse on the card clock has the full high and low width of its rate, including the first pulse after enabling and every pulse around a change of rate.

Top module: `clk_card_divider`

## Requirements
- R1: Starting from the first oscillator edge after reset is released, `aux_clk` toggles on every rising edge of `clk_osc`, whatever the enable and select inputs are doing.
- R2: While `rst_n` is low, `aux_clk` and `card_clk` are both low.
- R3: With `seq_enable`=1, `sel_fast_n`=0 and `sel_slow_n`=1 in effect, `card_clk` is high for one oscillator cycle and then low for one, giving a period of 2 oscillator cycles.
- R4: With `seq_enable`=1 and `sel_slow_n`=0 in effect, `card_clk` is high for two oscillator cycles and then low for two, giving a period of 4.
- R5: When both selects are low, the quarter rate of R4 is used.
- R6: When `seq_enable`=0, or when both selects are high, `card_clk` stays low once the current pulse has completed.
- R7: The three inputs are sampled only at `clk_osc` edges where `aux_clk` is high. A sampled value is used by the card clock logic no earlier than the second such sample edge after it was captured.
- R8: A rate change or a stop takes effect only at the end of a low phase. Every low phase that ends in a rising edge is exactly as long as the high phase before it, and no high phase is shorter than the rate it belongs to.
- R9: The first pulse after the card clock has been idle lasts the full high time of the selected rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_fast_n | input | 1 | Active-low select for the half rate |
| sel_slow_n | input | 1 | Active-low select for the quarter rate (takes priority) |
| seq_enable | input | 1 | Card clock enable from the sequencer |
| aux_clk | output | 1 | Free-running clock at half the oscillator rate |
| card_clk | output | 1 | Gated card clock |

## Verification
The risky overlap is a new synchronized request reaching the card clock logic in the same cycle that a pulse is still high or a low phase is just ending. The request must then wait for the low phase to finish, or be taken up at that exact cycle. To provoke this, the bench applies a change of rate, and separately a disable, at every offset from 0 to 7 oscillator cycles relative to a running pattern. This sweeps the arrival across all phase positions. Each cycle is judged against a behavioural reference model, and a separate run-length monitor confirms that no high or low phase was cut short.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int PH_W = 2;

  typedef enum logic [1:0] {
    RATE_OFF  = 2'd0,
    RATE_FAST = 2'd1,
    RATE_SLOW = 2'd2
  } rate_e;

  // Rate request from enable and the two active-low selects; slow wins.
  function automatic rate_e pick_rate(input logic en, input logic fast_n,
                                      input logic slow_n);
    rate_e r;
    if (!en)          r = RATE_OFF;
    else if (!slow_n) r = RATE_SLOW;
    else if (!fast_n) r = RATE_FAST;
    else              r = RATE_OFF;
    return r;
  endfunction

  // Oscillator cycles spent in each phase (high or low) at a given rate.
  function automatic logic [PH_W-1:0] phase_len(input rate_e r);
    logic [PH_W-1:0] n;
    case (r)
      RATE_FAST: n = PH_W'(1);
      RATE_SLOW: n = PH_W'(2);
      default:   n = '0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/clkdiv_prescaler.sv
module clkdiv_prescaler (
  input  logic clk,
  input  logic rst_n,
  output logic aux_o,
  output logic tick_o
);
  logic aux_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) aux_q <= 1'b0;
    else        aux_q <= ~aux_q;
  end

  assign aux_o  = aux_q;
  // Sample strobe: once per auxiliary period, while aux is high.
  assign tick_o = aux_q;

  p_aux_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (aux_q != $past(aux_q)));

endmodule

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    stage_q[g] <= RST_VAL;
        else if (tick) stage_q[g] <= (g == 0) ? d_i : stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

  p_sync_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(q_o));

endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate
  import clkdiv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  rate_e rate_req,
  output logic  card_o,
  output rate_e rate_o,
  output logic  load_o
);
  logic            card_q;
  rate_e           rate_q;
  logic [PH_W-1:0] left_q;
  logic            phase_end;

  assign phase_end = (left_q <= PH_W'(1));
  // Named event: a low phase is complete and a new request is taken up.
  assign load_o    = !card_q && phase_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      card_q <= 1'b0;
      rate_q <= RATE_OFF;
      left_q <= '0;
    end else if (card_q) begin
      if (phase_end) begin
        card_q <= 1'b0;
        left_q <= phase_len(rate_q);
      end else begin
        left_q <= left_q - PH_W'(1);
      end
    end else if (!phase_end) begin
      left_q <= left_q - PH_W'(1);
    end else begin
      rate_q <= rate_req;
      left_q <= phase_len(rate_req);
      card_q <= (rate_req != RATE_OFF);
    end
  end

  assign card_o = card_q;
  assign rate_o = rate_q;

  p_rate_change_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q != $past(rate_q)) |-> !$past(card_q));
  p_slow_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(card_q) && rate_q == RATE_SLOW) |=> card_q);
  p_fast_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(card_q) && rate_q == RATE_FAST) |=> !card_q);
  p_slow_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(card_q) && rate_q == RATE_SLOW) |=> !card_q);
  p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == RATE_OFF) |-> !card_q);

endmodule

// File: rtl/clk_card_divider.sv
module clk_card_divider
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_osc,
  input  logic rst_n,
  input  logic sel_fast_n,
  input  logic sel_slow_n,
  input  logic seq_enable,
  output logic aux_clk,
  output logic card_clk
);
  localparam int REQ_W = 3;
  localparam logic [REQ_W-1:0] REQ_IDLE = 3'b011; // enable off, selects high

  logic             tick;
  logic [REQ_W-1:0] req_raw;
  logic [REQ_W-1:0] req_sync;
  rate_e            rate_req;
  rate_e            rate_cur;
  logic             load_evt;

  clkdiv_prescaler u_pre (
    .clk    (clk_osc),
    .rst_n  (rst_n),
    .aux_o  (aux_clk),
    .tick_o (tick)
  );

  assign req_raw = {seq_enable, sel_slow_n, sel_fast_n};

  clkdiv_sync #(.WIDTH(REQ_W), .STAGES(SYNC_STAGES), .RST_VAL(REQ_IDLE)) u_sync (
    .clk   (clk_osc),
    .rst_n (rst_n),
    .tick  (tick),
    .d_i   (req_raw),
    .q_o   (req_sync)
  );

  assign rate_req = pick_rate(req_sync[2], req_sync[0], req_sync[1]);

  clkdiv_gate u_gate (
    .clk      (clk_osc),
    .rst_n    (rst_n),
    .rate_req (rate_req),
    .card_o   (card_clk),
    .rate_o   (rate_cur),
    .load_o   (load_evt)
  );

  p_start_on_load_r9: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $rose(card_clk) |-> $past(load_evt));
  p_slow_priority_r5: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (load_evt && req_sync == 3'b100) |=> (rate_cur == RATE_SLOW));

endmodule

// File: tb/tb_clk_card_divider.sv
module tb_clk_card_divider;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_n = 1'b1, slow_n = 1'b1, en = 1'b0;
  logic aux_clk, card_clk;

  int vectors = 0, errors = 0;
  bit done = 0;
  string tag = "R2";

  // reference model state
  int m_aux = 0, m_card = 0, m_left = 0, m_rate = 0;
  int q[$];
  // run-length monitor
  int prev_card = 0, run = 0, last_high = 0, idle_before = 1;

  always #(PERIOD/2) clk = ~clk;

  clk_card_divider dut (
    .clk_osc(clk), .rst_n(rst_n), .sel_fast_n(fast_n), .sel_slow_n(slow_n),
    .seq_enable(en), .aux_clk(aux_clk), .card_clk(card_clk)
  );

  function automatic int want_rate(int v);
    // v encodes {en, slow_n, fast_n}
    if ((v & 4) == 0) return 0;
    if ((v & 2) == 0) return 2;
    if ((v & 1) == 0) return 1;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  task automatic model_step();
    int cur = q[0];
    if (m_card == 1) begin
      if (m_left <= 1) begin m_card = 0; m_left = m_rate; end
      else m_left--;
    end else if (m_left > 1) begin
      m_left--;
    end else begin
      m_rate = want_rate(cur);
      m_left = m_rate;
      m_card = (m_rate != 0) ? 1 : 0;
    end
    if (m_aux == 1) begin
      void'(q.pop_front());
      q.push_back({29'd0, en, slow_n, fast_n});
    end
    m_aux = 1 - m_aux;
  endtask

  task automatic monitor();
    int c = int'(card_clk);
    if (c == prev_card) run++;
    else begin
      if (prev_card == 1) begin
        if (idle_before) check("R9", run, m_rate_at_fall);
        check("R8", int'(run == 1 || run == 2), 1);
        last_high = run;
        idle_before = 0;
      end else begin
        if (!idle_before) check("R8", run, last_high);
      end
      run = 1;
    end
    if (c == 0 && run > 2) idle_before = 1;
    prev_card = c;
  endtask

  int m_rate_at_fall = 0;

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      model_step();
      if (m_card == 1) m_rate_at_fall = m_rate;
      @(negedge clk);
      check(tag, int'(card_clk), m_card);
      check("R1", int'(aux_clk), m_aux);
      monitor();
    end
  endtask

  task automatic set_in(logic e, logic f, logic s);
    en = e; fast_n = f; slow_n = s;
  endtask

  initial begin
    q.push_back(3); q.push_back(3);
    repeat (3) @(negedge clk);
    tag = "R2";
    check("R2", int'(aux_clk), 0);
    check("R2", int'(card_clk), 0);
    set_in(1, 0, 1);
    @(negedge clk);
    check("R2", int'(card_clk), 0);
    set_in(0, 1, 1);
    rst_n = 1'b1;
    tag = "R6"; set_in(0, 0, 0); cyc(12);
    tag = "R6"; set_in(1, 1, 1); cyc(12);
    tag = "R7"; set_in(1, 0, 1); cyc(4);
    tag = "R3"; cyc(16);
    tag = "R4"; set_in(1, 1, 0); cyc(20);
    tag = "R5"; set_in(1, 0, 0); cyc(20);
    tag = "R6"; set_in(0, 0, 0); cyc(16);
    for (int off = 0; off < 8; off++) begin
      tag = "R8"; set_in(1, 0, 1); cyc(12 + off);
      set_in(1, 1, 0); cyc(14);
      set_in(1, 0, 1); cyc(3 + off);
      set_in(0, 0, 1); cyc(12);
      tag = "R9"; set_in(1, 1, 0); cyc(9 + off);
      tag = "R8"; set_in(1, 1, 1); cyc(12);
    end
    tag = "R3"; set_in(1, 0, 1); cyc(20);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog t=%0t actual=%0d expected=%0d", $time, 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule